// File: doc/BRIEF.md
# Periodic 64-bit Compare Timer

This block keeps a 64-bit up-counter that advances by one whenever the timer is switched on and an external tick enable is high. A 64-bit compare value is checked against the counter. When compare checking is on and the two are equal, a sticky event flag is raised. When the interrupt enable is also on, a level interrupt is raised. When stepping is on, every match also adds a programmable 32-bit step to the compare value. One setup then produces ticks at a fixed period with no drift and no software reload.

Software reaches every register over a plain 32-bit word-addressed bus. A write is taken on the clock edge where the write strobe is high. Read data is a combinational function of the address. The 64-bit counter and the 64-bit compare value each appear as a low word and a high word. Both words of the counter come from the same register, so software can read the high word, then the low word, then the high word again, and retry if the two high reads differ. There is no data stream at this block's edge, so no valid/ready handshake is used and every pin is plain.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The counter increases by one on each clock edge where control bit 0 (run) is 1 and `tick_en` is 1. Otherwise it holds.
- R3: The counter low word is at address 0 and the high word at address 1. The high word increases on the same edge where the low word wraps from 0xFFFFFFFF to 0. The whole counter wraps modulo 2^64.
- R4: A write to address 0 or 1 loads that counter word. Such a write takes precedence over counting on that edge.
- R5: Control is at address 2: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 step enable. Bits 31..4 read as 0 whatever was written.
- R6: The compare low word is at address 4, the compare high word at address 5 and the step at address 6. All three read back what was written.
- R7: While compare enable is 1 and the counter equals the compare value, status bit 0 (address 3) becomes 1 at the next clock edge.
- R8: A status write with bit 0 = 1 clears the flag. A status write with bit 0 = 0 leaves it unchanged.
- R9: When a match and a clearing write fall on the same edge, the flag remains 1.
- R10: When stepping is on, a match adds the step to the compare value on that edge, modulo 2^64. A compare-word write on the same edge wins.
- R11: `irq` is high exactly while the flag is 1 and interrupt enable is 1. It stays high until one of them drops (level output).
- R12: Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count qualifier; the counter advances only when high |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of actions can fall on the same edge, and the bench forces both.

The first pair is a compare match and a software clear of the flag. With the tick held low, the compare value is loaded equal to the frozen counter, so the match stays true. A clearing write is then issued. The flag must still read 1. Once the compare value has moved away, a second clearing write must leave it at 0.

The second pair is a counter increment that carries into the high word and, on another edge, a match whose step addition wraps the 64-bit compare value. Both are judged by reading the low and high words afterwards.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CTRL   = 3'd2,
    A_STAT   = 3'd3,
    A_CMP_LO = 3'd4,
    A_CMP_HI = 3'd5,
    A_STEP   = 3'd6,
    A_NONE   = 3'd7
  } gtmr_addr_e;

  // Control word, bit 0 is the last member
  typedef struct packed {
    logic step_on;
    logic irq_on;
    logic cmp_on;
    logic run;
  } gtmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(gtmr_ctrl_t);

endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (advance) count_d = count + CNT_W'(1);
    if (wr_lo) count_d[BUS_W-1:0] = wdata;
    if (wr_hi) count_d[CNT_W-1:BUS_W] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !wr_lo && !wr_hi) |=> $stable(count));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_lo && !wr_hi) |=> (count != $past(count)));

  a_r3_upper_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_lo && !wr_hi && (count[BUS_W-1:0] != '1))
      |=> $stable(count[CNT_W-1:BUS_W]));

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_on,
  input  logic             step_on,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_step,
  input  logic [BUS_W-1:0] wdata,
  output logic             match,
  output logic [CNT_W-1:0] cmp,
  output logic [BUS_W-1:0] step
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cmp_d;

  assign match = cmp_on && (count == cmp);

  always_comb begin
    cmp_d = cmp;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_d[BUS_W-1:0] = wdata;
      if (wr_hi) cmp_d[CNT_W-1:BUS_W] = wdata[HI_W-1:0];
    end else if (match && step_on) begin
      cmp_d = cmp + CNT_W'(step);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp  <= '0;
      step <= '0;
    end else begin
      cmp <= cmp_d;
      if (wr_step) step <= wdata;
    end
  end

  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (match && step_on && !wr_lo && !wr_hi)
      |=> (cmp == $past(cmp) + CNT_W'($past(step))));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !wr_lo && !wr_hi) |=> $stable(cmp));

endmodule

// File: rtl/gtmr_status.sv
module gtmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic irq_on,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= match | (flag & ~clr);
  end

  assign irq = flag & irq_on;

  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !flag);

  a_r11_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && irq_on));

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  import gtmr_pkg::*;

  localparam int unsigned HI_W = CNT_W - BUS_W;

  gtmr_ctrl_t       ctrl;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp;
  logic [BUS_W-1:0] step;
  logic             match;
  logic             flag;

  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;

  assign wr_cnt_lo = bus_we && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_we && (bus_addr == A_CNT_HI);
  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_stat   = bus_we && (bus_addr == A_STAT);
  assign wr_cmp_lo = bus_we && (bus_addr == A_CMP_LO);
  assign wr_cmp_hi = bus_we && (bus_addr == A_CMP_HI);
  assign wr_step   = bus_we && (bus_addr == A_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= gtmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  gtmr_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (ctrl.run && tick_en),
    .wr_lo   (wr_cnt_lo),
    .wr_hi   (wr_cnt_hi),
    .wdata   (bus_wdata),
    .count   (count)
  );

  gtmr_compare #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .cmp_on  (ctrl.cmp_on),
    .step_on (ctrl.step_on),
    .wr_lo   (wr_cmp_lo),
    .wr_hi   (wr_cmp_hi),
    .wr_step (wr_step),
    .wdata   (bus_wdata),
    .match   (match),
    .cmp     (cmp),
    .step    (step)
  );

  gtmr_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .match  (match),
    .clr    (wr_stat && bus_wdata[0]),
    .irq_on (ctrl.irq_on),
    .flag   (flag),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (gtmr_addr_e'(bus_addr))
      A_CNT_LO: bus_rdata = count[BUS_W-1:0];
      A_CNT_HI: bus_rdata = BUS_W'(count[CNT_W-1:BUS_W]);
      A_CTRL:   bus_rdata = BUS_W'(ctrl);
      A_STAT:   bus_rdata = BUS_W'(flag);
      A_CMP_LO: bus_rdata = cmp[BUS_W-1:0];
      A_CMP_HI: bus_rdata = BUS_W'(cmp[CNT_W-1:BUS_W]);
      A_STEP:   bus_rdata = step;
      default:  bus_rdata = '0;
    endcase
  end

  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl == $past(bus_wdata[CTRL_W-1:0])));

  a_r12_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_NONE) |-> (bus_rdata == '0));

  initial assert (HI_W > 0 && HI_W <= BUS_W);

endmodule

// File: tb/gtmr_top_tb_top.sv
`timescale 1ns/1ps
module gtmr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gtmr_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 run ticks, 3 irq-check
    logic [7:0]  req;
    logic [2:0]  addr;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'd4,  3'd0, 32'hFFFF_FFFD},  // R4 load low
    '{2'd0, 8'd4,  3'd1, 32'h0000_0007},  // R4 load high
    '{2'd1, 8'd4,  3'd0, 32'hFFFF_FFFD},
    '{2'd1, 8'd4,  3'd1, 32'h0000_0007},
    '{2'd0, 8'd5,  3'd2, 32'h0000_0001},  // R5 run only
    '{2'd1, 8'd5,  3'd2, 32'h0000_0001},
    '{2'd2, 8'd2,  3'd0, 32'd2},          // R2 two ticks
    '{2'd1, 8'd3,  3'd0, 32'hFFFF_FFFF},
    '{2'd1, 8'd3,  3'd1, 32'h0000_0007},
    '{2'd2, 8'd3,  3'd0, 32'd1},          // R3 carry tick
    '{2'd1, 8'd3,  3'd0, 32'h0000_0000},
    '{2'd1, 8'd3,  3'd1, 32'h0000_0008},
    '{2'd0, 8'd6,  3'd4, 32'h0000_0010},  // R6
    '{2'd0, 8'd6,  3'd5, 32'h0000_0008},
    '{2'd0, 8'd6,  3'd6, 32'h0000_0005},
    '{2'd1, 8'd6,  3'd4, 32'h0000_0010},
    '{2'd1, 8'd6,  3'd5, 32'h0000_0008},
    '{2'd1, 8'd6,  3'd6, 32'h0000_0005},
    '{2'd0, 8'd5,  3'd2, 32'hFFFF_FFFF},  // R5 upper bits dropped
    '{2'd1, 8'd5,  3'd2, 32'h0000_000F},
    '{2'd0, 8'd5,  3'd2, 32'h0000_000F},
    '{2'd1, 8'd7,  3'd3, 32'h0000_0000},  // R7 no match yet
    '{2'd2, 8'd7,  3'd0, 32'd17},         // R7 pass compare
    '{2'd1, 8'd7,  3'd3, 32'h0000_0001},
    '{2'd1, 8'd10, 3'd4, 32'h0000_0015},  // R10 stepped
    '{2'd1, 8'd2,  3'd0, 32'h0000_0011},
    '{2'd3, 8'd11, 3'd0, 32'd1},          // R11
    '{2'd0, 8'd8,  3'd3, 32'hFFFF_FFFE},  // R8 bit0 clear: ignored
    '{2'd1, 8'd8,  3'd3, 32'h0000_0001},
    '{2'd0, 8'd8,  3'd3, 32'h0000_0001},  // R8 clear
    '{2'd1, 8'd8,  3'd3, 32'h0000_0000},
    '{2'd3, 8'd11, 3'd0, 32'd0},
    '{2'd2, 8'd10, 3'd0, 32'd5},          // R10 next period
    '{2'd1, 8'd10, 3'd4, 32'h0000_001A},
    '{2'd1, 8'd7,  3'd3, 32'h0000_0001},
    '{2'd1, 8'd2,  3'd0, 32'h0000_0016},
    '{2'd0, 8'd11, 3'd2, 32'h0000_000B},  // R11 irq off
    '{2'd3, 8'd11, 3'd0, 32'd0},
    '{2'd1, 8'd8,  3'd3, 32'h0000_0001},
    '{2'd1, 8'd12, 3'd7, 32'h0000_0000},  // R12
    '{2'd1, 8'd5,  3'd2, 32'h0000_000B}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Every task starts and ends just after a falling edge.
  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic do_run(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_irq(input string tag, input logic exp);
    #1 chk(tag, {31'd0, irq}, {31'd0, exp});
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) do_rd("R1 reset read", 3'(a), 32'd0);
    do_irq("R1 reset irq", 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("table %0d R%0d", i, TBL[i].req);
      case (TBL[i].op)
        2'd0: do_wr(TBL[i].addr, TBL[i].val);
        2'd1: do_rd(tag, TBL[i].addr, TBL[i].val);
        2'd2: do_run(int'(TBL[i].val));
        default: do_irq(tag, TBL[i].val[0]);
      endcase
    end

    // R9 match and clear on the same edge (counter frozen at 8_00000016)
    do_wr(3'd2, 32'h3);
    do_wr(3'd4, 32'h16);
    do_wr(3'd3, 32'h1);
    do_rd("R9 match beats clear", 3'd3, 32'd1);
    do_wr(3'd4, 32'h40);
    do_wr(3'd3, 32'h1);
    do_rd("R8 clear after match gone", 3'd3, 32'd0);

    // R10 step addition wraps, R3 counter wraps
    do_wr(3'd2, 32'h0);
    do_wr(3'd0, 32'hFFFF_FFFE);
    do_wr(3'd1, 32'hFFFF_FFFF);
    do_wr(3'd4, 32'hFFFF_FFFE);
    do_wr(3'd5, 32'hFFFF_FFFF);
    do_wr(3'd6, 32'h5);
    do_wr(3'd2, 32'hB);
    do_run(1);
    do_rd("R10 wrap low",  3'd4, 32'h3);
    do_rd("R10 wrap high", 3'd5, 32'h0);
    do_rd("R7 flag after wrap match", 3'd3, 32'd1);
    do_rd("R2 count low", 3'd0, 32'hFFFF_FFFF);
    do_run(1);
    do_rd("R3 wrap low",  3'd0, 32'h0);
    do_rd("R3 wrap high", 3'd1, 32'h0);

    // R2 holds with tick low, and with run off
    repeat (3) @(negedge clk);
    do_rd("R2 hold tick low", 3'd0, 32'h0);
    do_wr(3'd2, 32'h0);
    do_run(4);
    do_rd("R2 hold run off", 3'd0, 32'h0);

    // R11 level output
    do_wr(3'd2, 32'h4);
    do_irq("R11 irq high", 1'b1);
    repeat (4) @(negedge clk);
    do_irq("R11 irq still high", 1'b1);
    do_wr(3'd3, 32'h1);
    do_irq("R11 irq drops on clear", 1'b0);

    finish_run();
  end

endmodule